// File: doc/BRIEF.md
# Counter Bank Overflow and Freeze Controller

This block holds the shared control and status state for a bank of up to 64 event counters. Software reaches it through a 64-bit register port. The port offers a read-only capability word, a per-counter freeze mask, and a per-counter overflow status word that software clears by writing ones. It also holds a small configuration word per counter. That word carries a run enable, an interrupt-on-overflow enable and a freeze-on-overflow enable.

The counter datapath sits outside the block. Each counter returns an overflow pulse, and the block sends back a run signal for it. A counter runs only when it is enabled and its freeze bit is clear, and overflow pulses are accepted only from running counters. An accepted overflow sets that counter's status bit. If the counter has freeze-on-overflow set, the same overflow freezes the whole bank, so that software can read a consistent snapshot. A single interrupt line is raised while any status bit is set for a counter that has interrupt-on-overflow enabled.

Writes take effect at the clock edge on which `reg_wr_en` is high. Reads are combinational from `reg_addr`. The offsets are 0x000 for capability, 0x010 for overflow status, 0x018 for freeze, and 0x200 + 8·n for the configuration of counter n.

Top module: `ofc_top`

## Requirements
- R1: The capability word at 0x000 reads NUM_CTR−1 in bits [5:0], CTR_W in [15:8], NUM_EVCAP−1 in [24:20] and IRQ_MSG in [47:44]. Bits 48 (writable while frozen), 49 (freeze supported) and 50 (interrupt supported) read one, and every other bit reads zero.
- R2: The configuration word at 0x200 + 8·n stores bit 8 (run enable), bit 9 (interrupt-on-overflow) and bit 10 (freeze-on-overflow). All its other bits read zero.
- R3: An overflow pulse on a counter whose `ctr_run` is high sets that counter's overflow status bit at that clock edge. A pulse on a counter that is not running is ignored.
- R4: A write to the overflow status word at 0x010 clears every bit written as one and leaves bits written as zero unchanged. When a clear and an accepted overflow hit the same bit in the same cycle, the bit ends set.
- R5: `irq` is high exactly while some counter has both its status bit and its interrupt-on-overflow bit set. It stays high until the status is cleared or that enable is removed.
- R6: An accepted overflow on a counter with freeze-on-overflow set sets the freeze bit of every implemented counter at that edge.
- R7: A write to the freeze word at 0x018 replaces the freeze mask, so all ones stops every counter and zero releases them all. `ctr_run[n]` is high only while counter n is enabled and not frozen.
- R8: Status and freeze bits at or above NUM_CTR read zero. Configuration writes to an index at or above NUM_CTR are ignored and read zero, and unmapped offsets read zero.
- R9: After reset all status, freeze and configuration bits are zero and `irq` is low.
- R10: If a software write to the freeze word and a hardware freeze-on-overflow fall in the same cycle, every implemented freeze bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` (combinational) |
| ovf_pulse | input | NUM_CTR | One-cycle overflow pulse per counter |
| ctr_run | output | NUM_CTR | Counter may advance (enabled and not frozen) |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions check four things on every cycle: that an accepted pulse always leaves its status bit set, that a ones-write clears bits nobody set again, that the interrupt never rises without a pending status bit, and that an automatic freeze or an all-ones freeze write stops the whole bank at the next edge. They also check that bits above the implemented counter count always read zero. The bench scenarios cover the rest. They show the exact capability encoding and the configuration bit placement, and that writes to out-of-range indices are ignored. They also show the same-cycle collisions, a clear against a set and a freeze write against an automatic freeze, and they show an overflow ignored while its counter is frozen or disabled.

// File: rtl/ofc_pkg.sv
package ofc_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 64;

    localparam logic [ADDR_W-1:0] A_CAP      = 12'h000;
    localparam logic [ADDR_W-1:0] A_OVF      = 12'h010;
    localparam logic [ADDR_W-1:0] A_FRZ      = 12'h018;
    localparam logic [ADDR_W-1:0] A_CFG_BASE = 12'h200;

    localparam int CFG_RUN_BIT = 8;
    localparam int CFG_IRQ_BIT = 9;
    localparam int CFG_FRZ_BIT = 10;

    typedef struct packed {
        logic frz_en;
        logic irq_en;
        logic run_en;
    } ctr_cfg_t;

    function automatic logic [DATA_W-1:0] cap_word(input int nctr, input int cw,
                                                   input int nevc, input int msg);
        logic [DATA_W-1:0] v;
        v        = '0;
        v[5:0]   = 6'(nctr - 1);
        v[15:8]  = 8'(cw);
        v[24:20] = 5'(nevc - 1);
        v[47:44] = 4'(msg);
        v[48]    = 1'b1;
        v[49]    = 1'b1;
        v[50]    = 1'b1;
        return v;
    endfunction

    function automatic logic cfg_hit(input logic [ADDR_W-1:0] a, input int idx);
        return a == (A_CFG_BASE + (ADDR_W'(idx) << 3));
    endfunction

endpackage

// File: rtl/ofc_cfg_slot.sv
module ofc_cfg_slot
    import ofc_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        wbits,
    output ctr_cfg_t          cfg_o
);

    ctr_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && cfg_hit(addr, IDX)) begin
            cfg_d.run_en = wbits[0];
            cfg_d.irq_en = wbits[1];
            cfg_d.frz_en = wbits[2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/ofc_status.sv
module ofc_status
    import ofc_pkg::*;
#(
    parameter int NUM_CTR = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_CTR-1:0] wdata,
    input  logic [NUM_CTR-1:0] accepted,
    input  logic               auto_frz,
    output logic [NUM_CTR-1:0] ovf_o,
    output logic [NUM_CTR-1:0] frz_o
);

    typedef struct packed {
        logic [NUM_CTR-1:0] ovf;
        logic [NUM_CTR-1:0] frz;
    } stat_t;

    stat_t st_d, st_q;
    logic [NUM_CTR-1:0] clr_mask;

    always_comb begin
        st_d     = st_q;
        clr_mask = (wr_en && addr == A_OVF) ? wdata : '0;
        // set has priority over a same-cycle clear
        st_d.ovf = (st_q.ovf & ~clr_mask) | accepted;
        if (wr_en && addr == A_FRZ) st_d.frz = wdata;
        if (auto_frz)               st_d.frz = '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovf_o = st_q.ovf;
    assign frz_o = st_q.frz;

endmodule

// File: rtl/ofc_rd_mux.sv
module ofc_rd_mux
    import ofc_pkg::*;
#(
    parameter int NUM_CTR   = 8,
    parameter int CTR_W     = 48,
    parameter int NUM_EVCAP = 4,
    parameter int IRQ_MSG   = 3
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_CTR-1:0] ovf,
    input  logic [NUM_CTR-1:0] frz,
    input  logic [NUM_CTR-1:0] run_en,
    input  logic [NUM_CTR-1:0] irq_en,
    input  logic [NUM_CTR-1:0] frz_en,
    output logic [DATA_W-1:0]  rdata
);

    localparam logic [DATA_W-1:0] CAP = cap_word(NUM_CTR, CTR_W, NUM_EVCAP, IRQ_MSG);

    always_comb begin
        rdata = '0;
        if (addr == A_CAP) begin
            rdata = CAP;
        end else if (addr == A_OVF) begin
            rdata = DATA_W'(ovf);
        end else if (addr == A_FRZ) begin
            rdata = DATA_W'(frz);
        end else begin
            for (int i = 0; i < NUM_CTR; i++) begin
                if (cfg_hit(addr, i)) begin
                    rdata[CFG_RUN_BIT] = run_en[i];
                    rdata[CFG_IRQ_BIT] = irq_en[i];
                    rdata[CFG_FRZ_BIT] = frz_en[i];
                end
            end
        end
    end

endmodule

// File: rtl/ofc_top.sv
module ofc_top
    import ofc_pkg::*;
#(
    parameter int NUM_CTR   = 8,
    parameter int CTR_W     = 48,
    parameter int NUM_EVCAP = 4,
    parameter int IRQ_MSG   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [11:0]        reg_addr,
    input  logic [63:0]        reg_wdata,
    output logic [63:0]        reg_rdata,
    input  logic [NUM_CTR-1:0] ovf_pulse,
    output logic [NUM_CTR-1:0] ctr_run,
    output logic               irq
);

    ctr_cfg_t           cfg [NUM_CTR];
    logic [NUM_CTR-1:0] run_en_vec, irq_en_vec, frz_en_vec;
    logic [NUM_CTR-1:0] ovf_vec, frz_vec, accepted;
    logic               auto_frz;
    logic               unused_wdata;

    assign unused_wdata = ^reg_wdata;

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_slot
        ofc_cfg_slot #(.IDX(g)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (reg_wr_en),
            .addr  (reg_addr),
            .wbits (reg_wdata[CFG_FRZ_BIT:CFG_RUN_BIT]),
            .cfg_o (cfg[g])
        );
        assign run_en_vec[g] = cfg[g].run_en;
        assign irq_en_vec[g] = cfg[g].irq_en;
        assign frz_en_vec[g] = cfg[g].frz_en;
    end

    assign ctr_run  = run_en_vec & ~frz_vec;
    assign accepted = ovf_pulse & ctr_run;
    assign auto_frz = |(accepted & frz_en_vec);
    assign irq      = |(ovf_vec & irq_en_vec);

    ofc_status #(.NUM_CTR(NUM_CTR)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata[NUM_CTR-1:0]),
        .accepted (accepted),
        .auto_frz (auto_frz),
        .ovf_o    (ovf_vec),
        .frz_o    (frz_vec)
    );

    ofc_rd_mux #(
        .NUM_CTR   (NUM_CTR),
        .CTR_W     (CTR_W),
        .NUM_EVCAP (NUM_EVCAP),
        .IRQ_MSG   (IRQ_MSG)
    ) u_rd (
        .addr   (reg_addr),
        .ovf    (ovf_vec),
        .frz    (frz_vec),
        .run_en (run_en_vec),
        .irq_en (irq_en_vec),
        .frz_en (frz_en_vec),
        .rdata  (reg_rdata)
    );

endmodule

// File: rtl/ofc_checker.sv
module ofc_checker
    import ofc_pkg::*;
#(
    parameter int NUM_CTR = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr_en,
    input logic [11:0]        reg_addr,
    input logic [63:0]        reg_wdata,
    input logic [63:0]        reg_rdata,
    input logic [NUM_CTR-1:0] ovf_pulse,
    input logic [NUM_CTR-1:0] ctr_run,
    input logic               irq,
    input logic [NUM_CTR-1:0] ovf_vec,
    input logic [NUM_CTR-1:0] frz_vec,
    input logic [NUM_CTR-1:0] frz_en_vec
);

    localparam logic [63:0] IMPL = 64'(({NUM_CTR{1'b1}}));
    logic [NUM_CTR-1:0] acc;
    assign acc = ovf_pulse & ctr_run;

    a_r3_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (acc != '0) |=> ((ovf_vec & $past(acc)) == $past(acc)));

    a_r4_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == A_OVF) |=>
        ((ovf_vec & $past(reg_wdata[NUM_CTR-1:0] & ~acc)) == '0));

    a_r5_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_vec != '0));

    a_r6_auto_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc & frz_en_vec) != '0) |=> (frz_vec == '1 && ctr_run == '0));

    a_r7_freeze_all: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == A_FRZ && reg_wdata[NUM_CTR-1:0] == '1) |=> (ctr_run == '0));

    a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_OVF || reg_addr == A_FRZ) |-> ((reg_rdata & ~IMPL) == 64'd0));

endmodule

bind ofc_top ofc_checker #(.NUM_CTR(NUM_CTR)) u_ofc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .ovf_pulse  (ovf_pulse),
    .ctr_run    (ctr_run),
    .irq        (irq),
    .ovf_vec    (ovf_vec),
    .frz_vec    (frz_vec),
    .frz_en_vec (frz_en_vec)
);

// File: tb/test_ofc_top.sv
module test_ofc_top;

    localparam int N = 8;
    localparam logic [11:0] CAP = 12'h000, OVF = 12'h010, FRZ = 12'h018;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [N-1:0] ovf_pulse = '0;
    logic [N-1:0] ctr_run;
    logic        irq;

    int checks = 0, errors = 0, cyc = 0;
    logic [N-1:0] m_en = '0, m_ie = '0, m_fe = '0, m_frz = '0, m_ovf = '0;

    always #4 clk = ~clk;

    ofc_top i_ofc_top (.*);

    function automatic logic [11:0] cfga(int n);
        return 12'h200 + 12'(n * 8);
    endfunction

    function automatic logic [63:0] exp_cap();
        return (64'(N - 1)) | (64'd48 << 8) | (64'd3 << 20) | (64'd3 << 44)
             | (64'd1 << 48) | (64'd1 << 49) | (64'd1 << 50);
    endfunction

    function automatic logic [63:0] exp_rd(logic [11:0] a);
        logic [63:0] v = '0;
        if (a == CAP) v = exp_cap();
        else if (a == OVF) v = 64'(m_ovf);
        else if (a == FRZ) v = 64'(m_frz);
        else for (int i = 0; i < N; i++)
            if (a == cfga(i)) v = (64'(m_en[i]) << 8) | (64'(m_ie[i]) << 9) | (64'(m_fe[i]) << 10);
        return v;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic rd(logic [11:0] a, string req);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp_rd(a));
    endtask

    // one clock: drive at negedge, model the edge, check outputs at next negedge
    task automatic step(bit wr, logic [11:0] a, logic [63:0] d, logic [N-1:0] p);
        logic [N-1:0] acc, n_ovf, n_frz;
        reg_wr_en = wr; reg_addr = a; reg_wdata = d; ovf_pulse = p;
        acc   = p & m_en & ~m_frz;
        n_ovf = (m_ovf & ~((wr && a == OVF) ? d[N-1:0] : '0)) | acc;
        n_frz = (wr && a == FRZ) ? d[N-1:0] : m_frz;
        if ((acc & m_fe) != '0) n_frz = '1;
        @(posedge clk);
        m_ovf = n_ovf; m_frz = n_frz;
        if (wr) for (int i = 0; i < N; i++)
            if (a == cfga(i)) begin m_en[i] = d[8]; m_ie[i] = d[9]; m_fe[i] = d[10]; end
        @(negedge clk);
        reg_wr_en = 1'b0; ovf_pulse = '0;
        chk("R5 irq", 64'(irq), 64'(|(m_ovf & m_ie)));
        chk("R7 ctr_run", 64'(ctr_run), 64'(m_en & ~m_frz));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL R9 watchdog act=%0d exp<%0d", cyc, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 irq", 64'(irq), 64'd0);
        chk("R9 run", 64'(ctr_run), 64'd0);
        rd(OVF, "R9 ovf"); rd(FRZ, "R9 frz"); rd(cfga(0), "R9 cfg");
        // R1 capability
        rd(CAP, "R1 cap");
        chk("R1 cap literal", reg_rdata, 64'h0007_3000_0030_3007);
        // R2 config bits
        step(1, cfga(2), 64'hFFFF_FFFF_FFFF_FFFF, '0);
        rd(cfga(2), "R2 cfg");
        chk("R2 cfg literal", reg_rdata, 64'h700);
        // R8 out-of-range index and unmapped address
        step(1, cfga(N), 64'h700, '0);
        rd(cfga(N), "R8 cfg idx");
        rd(12'h008, "R8 unmapped");
        step(1, FRZ, 64'hFFFF_FFFF_FFFF_FFFF, '0);
        rd(FRZ, "R8 frz upper");
        // R7 freeze all / release
        chk("R7 frozen", 64'(ctr_run), 64'd0);
        step(1, FRZ, 64'd0, '0);
        chk("R7 released", 64'(ctr_run), 64'h04);
        // R3 pulse on disabled counter ignored; enabled accepted
        step(1, cfga(0), 64'h100, '0);
        step(0, OVF, 0, 8'h02);
        rd(OVF, "R3 ignored");
        step(0, OVF, 0, 8'h01);
        rd(OVF, "R3 set");
        chk("R5 no irq w/o enable", 64'(irq), 64'd0);
        step(1, cfga(0), 64'h300, '0);
        chk("R5 irq", 64'(irq), 64'd1);
        // R4 set wins over same-cycle clear; zero bits unchanged
        step(1, OVF, 64'h01, 8'h05);
        rd(OVF, "R4 set wins");
        step(1, OVF, 64'h04, '0);
        rd(OVF, "R4 w1c");
        step(1, OVF, 64'h01, '0);
        chk("R5 irq drop", 64'(irq), 64'd0);
        // R3 frozen counter pulse ignored
        step(1, FRZ, 64'h01, '0);
        step(0, OVF, 0, 8'h01);
        rd(OVF, "R3 frozen ignored");
        step(1, FRZ, 64'h00, '0);
        // R6 freeze on overflow
        step(1, cfga(1), 64'h500, '0);
        step(0, OVF, 0, 8'h02);
        rd(FRZ, "R6 auto freeze");
        chk("R6 all frozen", 64'(ctr_run), 64'd0);
        // R10 freeze write collides with auto freeze
        step(1, FRZ, 64'd0, '0);
        step(1, FRZ, 64'd0, 8'h02);
        rd(FRZ, "R10 hw wins");
        step(1, FRZ, 64'd0, '0);
        step(1, OVF, 64'hFF, '0);
        // random phase
        for (int k = 0; k < 1500; k++) begin
            int sel = $urandom_range(0, 9);
            logic [11:0] a;
            logic [63:0] d = {$urandom, $urandom};
            logic [N-1:0] p = N'($urandom) & N'($urandom) & N'($urandom);
            if (sel < 3)      a = OVF;
            else if (sel < 5) begin a = FRZ; d = d & {$urandom, $urandom} & {$urandom, $urandom}; end
            else if (sel < 8) a = cfga($urandom_range(0, N + 1));
            else              a = CAP;
            step($urandom_range(0, 2) != 0, a, d, p);
            rd(OVF, "R3 R4 rand ovf");
            rd(FRZ, "R6 R7 rand frz");
            if (sel >= 5 && sel < 8) rd(a, "R2 R8 rand cfg");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule